// File: doc/BRIEF.md
# Board Control Register File

A memory-mapped control block for a development board. A host reaches it over a simple 32-bit bus that carries an address, a write strobe with data and a read strobe. Only the low 20 address bits select a register, so the block can sit anywhere in a larger window. It holds an 8-bit LED bar, a break/reset byte, a general-purpose output byte and an eight-character ASCII display buffer. It also has a soft-reset trigger that fires on one magic value, and a bit-banged two-wire port with clock and data outputs, an output-enable pair, a select bit and a live data input. It also returns fixed switch and status words.

The display can be loaded in two ways. One write turns a 32-bit word into eight uppercase hexadecimal characters. The other form replaces a single character through its own position register. The LED bits and the display bytes are brought out as plain vectors for the board logic. Read data is registered and is marked valid one cycle after the read strobe.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only address bits 19:0 are decoded, so a write at 0xABC00408 lands on the LED register. An offset with no register reads as 0, and a write to it changes no output and no readable register. An unused offset inside the character window, such as 0x41C, counts as unknown.
- R2: Offset 0x200 always reads 0. Offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1 and reads 0x10 when it is 0.
- R3: Offset 0x408 keeps bits 7:0 of a write, drives them on led_out and reads them back with the upper bits 0.
- R4: A write to 0x410 fills the whole display with the data word as eight uppercase hexadecimal ASCII characters ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46). Character 0 holds bits 31:28 and character 7 holds bits 3:0. Character i appears on disp_text[8i+7:8i].
- R5: A write to offset 0x418 + 8*i, for i from 0 to 7, replaces character i with bits 7:0 of the data and leaves the other characters unchanged.
- R6: A write of exactly 0x00000042 to 0x500 sets soft_rst_req high for the single cycle after the write edge. Any other value, including 0x142, leaves it low.
- R7: The register at 0x508 keeps 8 bits and drives brk_out. The register at 0xA00 keeps 8 bits and drives gp_out. The register at 0xB08 keeps 2 bits and drives i2c_oe. The register at 0xB18 keeps 1 bit. Each reads back zero-extended.
- R8: A write to 0xB10 stores the full 32-bit word and reads it back at the same offset. Bit 1 of that word drives i2c_scl_o and bit 0 drives i2c_sda_o.
- R9: A read of 0xB00 returns the stored input word, which is 3 after reset, with bit 0 replaced by i2c_sda_i as sampled at the read edge.
- R10: A read of 0xA08 returns the stored 0xB10 word when the select bit is 1, and returns 0 when it is 0.
- R11: After reset the registers hold these values: LEDs 0, break byte 0x0A, GP output 0, output enable 0, two-wire output word 3 (SCL = SDA = 1), select 1, every display character 0x20, soft_rst_req 0 and rd_valid 0.
- R12: A read strobe at one edge gives rd_valid = 1 and rd_data during the next cycle. rd_data holds the value from before any write at that same edge. Without a strobe, rd_valid = 0 and rd_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 19:0 decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rd_data valid this cycle |
| led_out | output | LED_W | LED bar bits |
| disp_text | output | 8*NUM_CHARS | Display characters, character 0 in the low byte |
| soft_rst_req | output | 1 | One-cycle soft reset request |
| brk_out | output | BYTE_W | Break/reset byte |
| gp_out | output | BYTE_W | General-purpose output byte |
| i2c_oe | output | 2 | Two-wire output enables |
| i2c_scl_o | output | 1 | Two-wire clock output |
| i2c_sda_o | output | 1 | Two-wire data output |
| i2c_sda_i | input | 1 | Live data line from the attached device |

## Verification
A read and a write can fall on the same edge, at the same offset or at different ones. The read must return the state from before the write, while the write still takes effect. The bench provokes this by strobing both at once on the LED, two-wire output and display registers. It judges the returned word against the bench model taken before the write, and then judges a follow-up read against the model taken after it. The random phase also lets the live data input change at every read, so the merged input word is checked against whatever value the line had at that read edge.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;
   localparam int OFF_W = 20;

   localparam logic [OFF_W-1:0] OFF_SWITCH  = 20'h00200;
   localparam logic [OFF_W-1:0] OFF_STATUS  = 20'h00208;
   localparam logic [OFF_W-1:0] OFF_LEDS    = 20'h00408;
   localparam logic [OFF_W-1:0] OFF_HEXWORD = 20'h00410;
   localparam logic [OFF_W-1:0] OFF_CHAR0   = 20'h00418;
   localparam int               CHAR_STRIDE = 8;
   localparam logic [OFF_W-1:0] OFF_SOFTRST = 20'h00500;
   localparam logic [OFF_W-1:0] OFF_BRK     = 20'h00508;
   localparam logic [OFF_W-1:0] OFF_GPOUT   = 20'h00A00;
   localparam logic [OFF_W-1:0] OFF_GPIN    = 20'h00A08;
   localparam logic [OFF_W-1:0] OFF_WIREIN  = 20'h00B00;
   localparam logic [OFF_W-1:0] OFF_WIREOE  = 20'h00B08;
   localparam logic [OFF_W-1:0] OFF_WIREOUT = 20'h00B10;
   localparam logic [OFF_W-1:0] OFF_WIRESEL = 20'h00B18;

   localparam logic [31:0] SOFTRST_KEY = 32'h0000_0042;
   localparam logic [7:0]  BRK_RST     = 8'h0A;
   localparam logic [31:0] WIRE_RST    = 32'h0000_0003;
   localparam logic [7:0]  SPACE_CHAR  = 8'h20;
   localparam logic [31:0] STATUS_BE   = 32'h0000_0012;
   localparam logic [31:0] STATUS_LE   = 32'h0000_0010;

   typedef struct packed {
      logic sw;
      logic status;
      logic leds;
      logic hexword;
      logic softrst;
      logic brk;
      logic gpout;
      logic gpin;
      logic wirein;
      logic wireoe;
      logic wireout;
      logic wiresel;
   } hit_t;

   function automatic logic [7:0] nibble_to_ascii(input logic [3:0] n);
      if (n < 4'd10) return 8'h30 + {4'd0, n};
      else           return 8'h37 + {4'd0, n};
   endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
   import board_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_CHARS = 8
) (
   input  logic [ADDR_W-1:0]    bus_addr,
   output hit_t                 hit,
   output logic [NUM_CHARS-1:0] char_hit
);
   logic [OFF_W-1:0] off;
   assign off = bus_addr[OFF_W-1:0];

   always_comb begin
      hit         = '0;
      hit.sw      = (off == OFF_SWITCH);
      hit.status  = (off == OFF_STATUS);
      hit.leds    = (off == OFF_LEDS);
      hit.hexword = (off == OFF_HEXWORD);
      hit.softrst = (off == OFF_SOFTRST);
      hit.brk     = (off == OFF_BRK);
      hit.gpout   = (off == OFF_GPOUT);
      hit.gpin    = (off == OFF_GPIN);
      hit.wirein  = (off == OFF_WIREIN);
      hit.wireoe  = (off == OFF_WIREOE);
      hit.wireout = (off == OFF_WIREOUT);
      hit.wiresel = (off == OFF_WIRESEL);
   end

   for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
      localparam logic [OFF_W-1:0] CHAR_OFF = OFF_CHAR0 + OFF_W'(i * CHAR_STRIDE);
      assign char_hit[i] = (off == CHAR_OFF);
   end
endmodule

// File: rtl/bcr_display.sv
module bcr_display
   import board_ctrl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_CHARS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hex_we,
   input  logic [NUM_CHARS-1:0]   char_we,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [8*NUM_CHARS-1:0] text
);
   for (genvar i = 0; i < NUM_CHARS; i++) begin : g_cell
      localparam int NIB = NUM_CHARS - 1 - i;
      logic [7:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          cell_q <= SPACE_CHAR;
         else if (hex_we)     cell_q <= nibble_to_ascii(wr_data[4*NIB +: 4]);
         else if (char_we[i]) cell_q <= wr_data[7:0];
      end
      assign text[8*i +: 8] = cell_q;
   end
endmodule

// File: rtl/bcr_wire_port.sv
module bcr_wire_port
   import board_ctrl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oe_we,
   input  logic              out_we,
   input  logic              sel_we,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sda_i,
   output logic [1:0]        oe,
   output logic              scl_o,
   output logic              sda_o,
   output logic              sel,
   output logic [DATA_W-1:0] out_word,
   output logic [DATA_W-1:0] in_word,
   output logic [DATA_W-1:0] gpin_word
);
   localparam logic [DATA_W-1:0] IN_STORED = DATA_W'(WIRE_RST);

   logic [1:0]        oe_q;
   logic              sel_q;
   logic [DATA_W-1:0] out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q  <= 2'b00;
         sel_q <= 1'b1;
         out_q <= DATA_W'(WIRE_RST);
      end else begin
         if (oe_we)  oe_q  <= wr_data[1:0];
         if (sel_we) sel_q <= wr_data[0];
         if (out_we) out_q <= wr_data;
      end
   end

   assign oe        = oe_q;
   assign sel       = sel_q;
   assign out_word  = out_q;
   assign scl_o     = out_q[1];
   assign sda_o     = out_q[0];
   assign in_word   = {IN_STORED[DATA_W-1:1], sda_i};
   assign gpin_word = sel_q ? out_q : '0;
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
   import board_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_CHARS  = 8,
   parameter int LED_W      = 8,
   parameter int BYTE_W     = 8,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   wr_en,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   rd_valid,
   output logic [LED_W-1:0]       led_out,
   output logic [8*NUM_CHARS-1:0] disp_text,
   output logic                   soft_rst_req,
   output logic [BYTE_W-1:0]      brk_out,
   output logic [BYTE_W-1:0]      gp_out,
   output logic [1:0]             i2c_oe,
   output logic                   i2c_scl_o,
   output logic                   i2c_sda_o,
   input  logic                   i2c_sda_i
);
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("ADDR_W must cover the decoded offset");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (NUM_CHARS * 4 != DATA_W) begin : g_bad_chars
      $error("NUM_CHARS must equal DATA_W/4");
   end
   if (LED_W > DATA_W || BYTE_W > DATA_W) begin : g_bad_bytes
      $error("register widths exceed DATA_W");
   end

   hit_t                 hit;
   logic [NUM_CHARS-1:0] char_hit;

   bcr_decode #(.ADDR_W(ADDR_W), .NUM_CHARS(NUM_CHARS)) u_decode (
      .bus_addr (bus_addr),
      .hit      (hit),
      .char_hit (char_hit)
   );

   bcr_display #(.DATA_W(DATA_W), .NUM_CHARS(NUM_CHARS)) u_display (
      .clk     (clk),
      .rst_n   (rst_n),
      .hex_we  (wr_en & hit.hexword),
      .char_we (char_hit & {NUM_CHARS{wr_en}}),
      .wr_data (wr_data),
      .text    (disp_text)
   );

   logic              wire_sel;
   logic [DATA_W-1:0] wire_out_word, wire_in_word, gpin_word;

   bcr_wire_port #(.DATA_W(DATA_W)) u_wire (
      .clk       (clk),
      .rst_n     (rst_n),
      .oe_we     (wr_en & hit.wireoe),
      .out_we    (wr_en & hit.wireout),
      .sel_we    (wr_en & hit.wiresel),
      .wr_data   (wr_data),
      .sda_i     (i2c_sda_i),
      .oe        (i2c_oe),
      .scl_o     (i2c_scl_o),
      .sda_o     (i2c_sda_o),
      .sel       (wire_sel),
      .out_word  (wire_out_word),
      .in_word   (wire_in_word),
      .gpin_word (gpin_word)
   );

   logic [DATA_W-1:0] status_word;
   if (BIG_ENDIAN) begin : g_status_be
      assign status_word = DATA_W'(STATUS_BE);
   end else begin : g_status_le
      assign status_word = DATA_W'(STATUS_LE);
   end

   logic [LED_W-1:0]  led_q;
   logic [BYTE_W-1:0] brk_q, gp_q;
   logic              soft_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led_q  <= '0;
         brk_q  <= BYTE_W'(BRK_RST);
         gp_q   <= '0;
         soft_q <= 1'b0;
      end else begin
         if (wr_en && hit.leds)  led_q <= wr_data[LED_W-1:0];
         if (wr_en && hit.brk)   brk_q <= wr_data[BYTE_W-1:0];
         if (wr_en && hit.gpout) gp_q  <= wr_data[BYTE_W-1:0];
         soft_q <= wr_en && hit.softrst && (wr_data == DATA_W'(SOFTRST_KEY));
      end
   end

   assign led_out      = led_q;
   assign brk_out      = brk_q;
   assign gp_out       = gp_q;
   assign soft_rst_req = soft_q;

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit.status)  rd_mux = status_word;
      if (hit.leds)    rd_mux = DATA_W'(led_q);
      if (hit.brk)     rd_mux = DATA_W'(brk_q);
      if (hit.gpout)   rd_mux = DATA_W'(gp_q);
      if (hit.gpin)    rd_mux = gpin_word;
      if (hit.wirein)  rd_mux = wire_in_word;
      if (hit.wireoe)  rd_mux = DATA_W'(i2c_oe);
      if (hit.wireout) rd_mux = wire_out_word;
      if (hit.wiresel) rd_mux = DATA_W'(wire_sel);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/board_ctrl_chk.sv
module board_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] bus_addr,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic        rd_en,
   input logic [31:0] rd_data,
   input logic        rd_valid,
   input logic [7:0]  led_out,
   input logic        soft_rst_req,
   input logic        i2c_scl_o,
   input logic        i2c_sda_o
);
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |=> !soft_rst_req);

   a_r6_only_on_key: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |-> $past(wr_en && bus_addr[19:0] == 20'h00500 && wr_data == 32'h42));

   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_valid && rd_data == 32'h0));

   a_r3_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(led_out));

   a_r8_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr[19:0] == 20'h00B10) |=>
         (i2c_scl_o == $past(wr_data[1]) && i2c_sda_o == $past(wr_data[0])));
endmodule

bind board_ctrl_regs board_ctrl_chk u_chk (.*);

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [7:0]  led_out;
   logic [63:0] disp_text;
   logic        soft_rst_req;
   logic [7:0]  brk_out, gp_out;
   logic [1:0]  i2c_oe;
   logic        i2c_scl_o, i2c_sda_o;
   logic        i2c_sda_i = 1'b1;

   board_ctrl_regs i_board_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .led_out(led_out), .disp_text(disp_text), .soft_rst_req(soft_rst_req),
      .brk_out(brk_out), .gp_out(gp_out), .i2c_oe(i2c_oe),
      .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_sda_i(i2c_sda_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad   = 0;

   // bench model
   logic [7:0]  m_led, m_brk, m_gp;
   logic [1:0]  m_oe;
   logic        m_sel;
   logic [31:0] m_wout;
   logic [63:0] m_text;

   function automatic logic [7:0] hex_ascii(input logic [3:0] n);
      return (n < 10) ? (8'd48 + 8'(n)) : (8'd65 + 8'(n) - 8'd10);
   endfunction

   function automatic logic [31:0] exp_read(input logic [19:0] off, input logic sda);
      case (off)
         20'h00208: return 32'h12;
         20'h00408: return {24'd0, m_led};
         20'h00508: return {24'd0, m_brk};
         20'h00A00: return {24'd0, m_gp};
         20'h00A08: return m_sel ? m_wout : 32'd0;
         20'h00B00: return {31'd1, sda};
         20'h00B08: return {30'd0, m_oe};
         20'h00B10: return m_wout;
         20'h00B18: return {31'd0, m_sel};
         default:   return 32'd0;
      endcase
   endfunction

   task automatic model_write(input logic [31:0] a, input logic [31:0] d);
      logic [19:0] off = a[19:0];
      case (off)
         20'h00408: m_led  = d[7:0];
         20'h00508: m_brk  = d[7:0];
         20'h00A00: m_gp   = d[7:0];
         20'h00B08: m_oe   = d[1:0];
         20'h00B10: m_wout = d;
         20'h00B18: m_sel  = d[0];
         20'h00410: for (int i = 0; i < 8; i++) m_text[8*i +: 8] = hex_ascii(d[4*(7-i) +: 4]);
         default: begin
            if (off >= 20'h00418 && off <= 20'h00450 && off[2:0] == 3'd0)
               m_text[8*((off - 20'h00418) >> 3) +: 8] = d[7:0];
         end
      endcase
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      check({req, " led_out"}, 64'(led_out), 64'(m_led));
      check({req, " disp_text"}, disp_text, m_text);
      check({req, " pins"}, 64'({brk_out, gp_out, i2c_oe, i2c_scl_o, i2c_sda_o}),
            64'({m_brk, m_gp, m_oe, m_wout[1], m_wout[0]}));
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; bus_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_read(input logic [31:0] a, output logic [31:0] v, output logic vld);
      @(negedge clk);
      rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data; vld = rd_valid;
   endtask

   task automatic read_check(input string req, input logic [31:0] a);
      logic [31:0] v; logic vld;
      logic [31:0] e = exp_read(a[19:0], i2c_sda_i);
      do_read(a, v, vld);
      check(req, {31'd0, vld, v}, {31'd0, 1'b1, e});
   endtask

   logic [31:0] offs [0:18] = '{32'h200, 32'h208, 32'h210, 32'h408, 32'h410, 32'h418,
                                32'h430, 32'h450, 32'h500, 32'h508, 32'hA00, 32'hA08,
                                32'hB00, 32'hB08, 32'hB10, 32'hB18, 32'h404, 32'h41C,
                                32'h458};

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v; logic vld; logic [31:0] seed_v;
      seed_v = $urandom(32'd1234);
      m_led = 0; m_brk = 8'h0A; m_gp = 0; m_oe = 0; m_sel = 1; m_wout = 32'd3;
      m_text = {8{8'h20}};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset values
      check_outputs("R11");
      check("R11 soft/valid", 64'({soft_rst_req, rd_valid, rd_data}), 64'd0);
      read_check("R11 wire out", 32'hB10);
      read_check("R11 select", 32'hB18);
      read_check("R11 brk", 32'h508);

      // R2 fixed words
      read_check("R2 switch", 32'h200);
      read_check("R2 status", 32'h208);

      // R3 LED byte
      do_write(32'h408, 32'hABCD_1234);
      check_outputs("R3");
      read_check("R3 led read", 32'h408);

      // R1 aliasing, unknown offsets
      do_write(32'hABC0_0408, 32'h0000_00C3);
      check("R1 alias", 64'(led_out), 64'hC3);
      do_write(32'h404, 32'hFFFF_FFFF);
      do_write(32'h41C, 32'hFFFF_FFFF);
      do_write(32'hB00, 32'h0);
      check_outputs("R1 ignored");
      read_check("R1 unknown read", 32'h404);
      read_check("R1 input after write", 32'hB00);

      // R4 hex word
      do_write(32'h410, 32'h1F2E_3D4C);
      check("R4 hex text", disp_text, {"C","4","D","3","E","2","F","1"});
      check_outputs("R4");

      // R5 single chars
      do_write(32'h418 + 8*5, 32'hFFFF_FF41);
      do_write(32'h450, 32'h1234_5678);
      check_outputs("R5");

      // R6 soft reset key
      @(negedge clk);
      wr_en = 1'b1; bus_addr = 32'h500; wr_data = 32'h42;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 pulse high", 64'(soft_rst_req), 64'd1);
      @(negedge clk);
      check("R6 pulse one cycle", 64'(soft_rst_req), 64'd0);
      @(negedge clk);
      wr_en = 1'b1; bus_addr = 32'h500; wr_data = 32'h142;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 other value", 64'(soft_rst_req), 64'd0);

      // R7 width masks
      do_write(32'h508, 32'hFFFF_FF55);
      do_write(32'hA00, 32'h1234_56A9);
      do_write(32'hB08, 32'hFFFF_FFFF);
      do_write(32'hB18, 32'hFFFF_FFFE);
      check_outputs("R7");
      read_check("R7 oe", 32'hB08);
      read_check("R7 sel", 32'hB18);
      read_check("R10 gpin sel0", 32'hA08);

      // R8 wire output word
      do_write(32'hB10, 32'hDEAD_BEE2);
      check_outputs("R8");
      read_check("R8 readback", 32'hB10);
      do_write(32'hB18, 32'h1);
      read_check("R10 gpin sel1", 32'hA08);

      // R9 live data input
      i2c_sda_i = 1'b0;
      read_check("R9 sda0", 32'hB00);
      i2c_sda_i = 1'b1;
      read_check("R9 sda1", 32'hB00);

      // R12 read and write on the same edge
      begin
         logic [31:0] e_old;
         e_old = exp_read(20'h408, 1'b0);
         @(negedge clk);
         wr_en = 1'b1; rd_en = 1'b1; bus_addr = 32'h408; wr_data = 32'h0000_0077;
         @(negedge clk);
         wr_en = 1'b0; rd_en = 1'b0;
         model_write(32'h408, 32'h77);
         check("R12 old value", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, e_old});
         @(negedge clk);
         check("R12 idle", {31'd0, rd_valid, rd_data}, 64'd0);
         read_check("R12 new value", 32'h408);
      end

      // random phase
      for (int n = 0; n < 400; n++) begin
         logic [31:0] a, d;
         a = offs[$urandom_range(0, 18)];
         if ($urandom_range(0, 3) == 0) a[31:20] = 12'($urandom);
         d = $urandom;
         i2c_sda_i = 1'($urandom);
         case ($urandom_range(0, 2))
            0: begin
               do_write(a, d);
               check_outputs("R1 R3 R4 R5 R7 R8 random");
            end
            1: read_check("R2 R9 R10 random read", a);
            default: begin
               logic [31:0] e_old;
               e_old = exp_read(a[19:0], i2c_sda_i);
               @(negedge clk);
               wr_en = 1'b1; rd_en = 1'b1; bus_addr = a; wr_data = d;
               @(negedge clk);
               wr_en = 1'b0; rd_en = 1'b0;
               model_write(a, d);
               check("R12 random same edge", {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, e_old});
               check_outputs("R12 random after");
            end
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule